// File: doc/BRIEF.md
# USB IN Endpoint Transmit Control

This block runs the upstream (device-to-host) half of a full-speed USB device for a parameterised set of endpoints. For each endpoint it keeps a transmit descriptor: a buffer identifier, a byte count, a ready bit, a cancel-record flag, a sent flag and a data toggle. When the token decoder reports an IN token, the block chooses one of three answers: data from the described buffer, NAK, or STALL. It then issues a one-cycle request to the serializer. After data, it waits for the serializer to finish and then for the host handshake.

Firmware prepares a buffer, writes its descriptor with the ready bit set, and waits for the sent flag, which drives a level interrupt. A SETUP that arrives on a control endpoint withdraws any armed descriptor on that endpoint, and so does a bus reset. The sticky cancel-record flag shows firmware that it must submit the buffer again. Serialization, CRC generation and the packet memory live in neighbouring blocks.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset all ready, cancel-record and sent flags are 0, the interrupt is low, no transmit request is issued, and every toggle is DATA0.
- R2: An IN token whose endpoint number is not below NUM_EP, or whose endpoint has its IN enable clear, produces no transmit request.
- R3: An endpoint is effectively isochronous when its iso bit is set and its SETUP-enable bit is clear. An IN to an enabled endpoint with stall set that is not effectively isochronous is answered with STALL (kind 2). This holds whatever its ready bit is.
- R4: An IN to an enabled endpoint that is not stalled (or is effectively isochronous) and not ready is answered with NAK (kind 1).
- R5: An IN to an enabled ready endpoint that is not stalled is answered with DATA (kind 0), the stored buffer ID and length min(size, MAX_PKT). A size of 0 gives a length of 0, meaning a CRC-only packet.
- R6: For a non-isochronous endpoint, a host ACK after the data has been sent clears ready and sets sent in the same clock edge. It also flips the endpoint's toggle, which is reported as tx_data1_o on the next DATA.
- R7: For an effectively isochronous endpoint, the end of data transmission clears ready and sets sent without waiting for a handshake, and the toggle is left unchanged.
- R8: While an ACK is awaited, a bad packet or a different token produces a one-cycle in_err_o pulse, and ready and sent are left unchanged. If nothing arrives within ACK_TIMEOUT cycles, the wait is abandoned without the pulse.
- R9: A SETUP on an endpoint whose SETUP-enable is set clears that endpoint's ready bit, and sets its cancel-record flag if ready was set. When SETUP-enable is clear, the SETUP has no effect on ready or the cancel-record flag.
- R10: A link reset clears every ready bit, sets the cancel-record flag of every endpoint that was ready, and returns all toggles to DATA0.
- R11: Cancel-record and sent flags clear only when a 1 is written to their clear masks. A hardware set in the same cycle as a clear wins.
- R12: pkt_sent_irq_o is high exactly while any sent flag is set.
- R13: A 1 in the toggle-clear mask returns that endpoint's toggle to DATA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| sw_wr_i | input | 1 | Descriptor write strobe |
| sw_ep_i | input | EP_W | Endpoint being written |
| sw_buf_i | input | BUF_W | Buffer ID to store |
| sw_size_i | input | SIZE_W | Byte count to store |
| sw_rdy_i | input | 1 | Ready value to store |
| pend_clr_i | input | NUM_EP | Write-1 clear of cancel-record flags |
| sent_clr_i | input | NUM_EP | Write-1 clear of sent flags |
| tgl_clr_i | input | NUM_EP | Reset toggle to DATA0 |
| in_en_i | input | NUM_EP | IN enable per endpoint |
| stall_i | input | NUM_EP | IN stall per endpoint |
| iso_i | input | NUM_EP | Isochronous per endpoint |
| setup_en_i | input | NUM_EP | SETUP accepted per endpoint |
| tok_in_i | input | 1 | IN token received (pulse) |
| tok_ep_i | input | EP_W | Endpoint of IN token |
| tx_done_i | input | 1 | Serializer finished the data packet |
| ack_i | input | 1 | Valid ACK handshake received |
| bad_pkt_i | input | 1 | Corrupt packet or CRC received |
| other_tok_i | input | 1 | A token other than ACK received |
| setup_rx_i | input | 1 | SETUP packet accepted (pulse) |
| setup_ep_i | input | EP_W | Endpoint of SETUP |
| link_rst_i | input | 1 | Bus reset detected (pulse) |
| tx_start_o | output | 1 | Transmit request (one cycle) |
| tx_kind_o | output | 2 | 0 DATA, 1 NAK, 2 STALL |
| tx_buf_o | output | BUF_W | Buffer ID for DATA |
| tx_len_o | output | SIZE_W | Clamped length for DATA |
| tx_data1_o | output | 1 | 1 selects DATA1 PID |
| in_err_o | output | 1 | Handshake error pulse |
| rdy_o | output | NUM_EP | Ready bits |
| pend_o | output | NUM_EP | Cancel-record flags |
| sent_o | output | NUM_EP | Sent flags |
| pkt_sent_irq_o | output | 1 | Packet-sent interrupt level |

## Verification
Every cycle, the assertions check several properties. The requested length never exceeds MAX_PKT. A link reset leaves no endpoint ready and leaves a cancel record for each endpoint that had been armed. The sent and cancel-record flags never drop without a clear. An enabled SETUP always disarms its endpoint, the error pulse lasts one cycle, and the interrupt only rises after a handshake or a completed isochronous send. Other behaviours can only be shown by the bench's sweep over enable, stall, iso, SETUP-enable and ready combinations on every endpoint, including one out of range: which answer an IN token gets, the stored buffer and length, the alternation of the toggle, the timeout path, and the set-wins collision rule.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;

    typedef enum logic [1:0] {
        RSP_DATA  = 2'd0,
        RSP_NAK   = 2'd1,
        RSP_STALL = 2'd2
    } rsp_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SEND = 2'd1,
        SQ_WACK = 2'd2
    } seq_state_e;

endpackage

// File: rtl/usb_in_len_clamp.sv
module usb_in_len_clamp #(
    parameter int SIZE_W  = 7,
    parameter int MAX_PKT = 64
) (
    input  logic [SIZE_W-1:0] size_i,
    output logic [SIZE_W-1:0] len_o
);
    localparam logic [SIZE_W-1:0] CAP = SIZE_W'(MAX_PKT);

    always_comb begin
        len_o = (size_i > CAP) ? CAP : size_i;
    end
endmodule

// File: rtl/usb_in_ep_regs.sv
module usb_in_ep_regs #(
    parameter int NUM_EP = 12,
    parameter int EP_W   = 4,
    parameter int BUF_W  = 5,
    parameter int SIZE_W = 7
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          sw_wr_i,
    input  logic [EP_W-1:0]               sw_ep_i,
    input  logic [BUF_W-1:0]              sw_buf_i,
    input  logic [SIZE_W-1:0]             sw_size_i,
    input  logic                          sw_rdy_i,
    input  logic [NUM_EP-1:0]             pend_clr_i,
    input  logic [NUM_EP-1:0]             sent_clr_i,
    input  logic [NUM_EP-1:0]             tgl_clr_i,
    input  logic                          done_i,
    input  logic [EP_W-1:0]               done_ep_i,
    input  logic                          done_flip_i,
    input  logic                          setup_v_i,
    input  logic [EP_W-1:0]               setup_ep_i,
    input  logic [NUM_EP-1:0]             setup_en_i,
    input  logic                          link_rst_i,
    output logic [NUM_EP-1:0][BUF_W-1:0]  bufs_o,
    output logic [NUM_EP-1:0][SIZE_W-1:0] sizes_o,
    output logic [NUM_EP-1:0]             rdy_o,
    output logic [NUM_EP-1:0]             pend_o,
    output logic [NUM_EP-1:0]             sent_o,
    output logic [NUM_EP-1:0]             tgl_o
);
    typedef struct packed {
        logic [NUM_EP-1:0][BUF_W-1:0]  bufs;
        logic [NUM_EP-1:0][SIZE_W-1:0] sizes;
        logic [NUM_EP-1:0]             rdy;
        logic [NUM_EP-1:0]             pend;
        logic [NUM_EP-1:0]             sent;
        logic [NUM_EP-1:0]             tgl;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d      = bank_q;
        bank_d.pend = bank_q.pend & ~pend_clr_i;
        bank_d.sent = bank_q.sent & ~sent_clr_i;
        for (int i = 0; i < NUM_EP; i++) begin
            // lowest priority: handshake completion
            if (done_i && done_ep_i == EP_W'(i)) begin
                bank_d.rdy[i]  = 1'b0;
                bank_d.sent[i] = 1'b1;
                if (done_flip_i) begin
                    bank_d.tgl[i] = ~bank_q.tgl[i];
                end
            end
            // firmware descriptor write
            if (sw_wr_i && sw_ep_i == EP_W'(i)) begin
                bank_d.bufs[i]  = sw_buf_i;
                bank_d.sizes[i] = sw_size_i;
                bank_d.rdy[i]   = sw_rdy_i;
            end
            if (tgl_clr_i[i]) begin
                bank_d.tgl[i] = 1'b0;
            end
            // hardware cancellation by SETUP
            if (setup_v_i && setup_ep_i == EP_W'(i) && setup_en_i[i]) begin
                if (bank_q.rdy[i]) begin
                    bank_d.pend[i] = 1'b1;
                end
                bank_d.rdy[i] = 1'b0;
            end
        end
        // highest priority: bus reset cancels everything
        if (link_rst_i) begin
            bank_d.pend = bank_d.pend | bank_q.rdy;
            bank_d.rdy  = '0;
            bank_d.tgl  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bufs_o  = bank_q.bufs;
    assign sizes_o = bank_q.sizes;
    assign rdy_o   = bank_q.rdy;
    assign pend_o  = bank_q.pend;
    assign sent_o  = bank_q.sent;
    assign tgl_o   = bank_q.tgl;
endmodule

// File: rtl/usb_in_seq.sv
module usb_in_seq
    import usb_in_pkg::*;
#(
    parameter int NUM_EP      = 12,
    parameter int EP_W        = 4,
    parameter int BUF_W       = 5,
    parameter int SIZE_W      = 7,
    parameter int MAX_PKT     = 64,
    parameter int ACK_TIMEOUT = 32
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          tok_in_i,
    input  logic [EP_W-1:0]               tok_ep_i,
    input  logic [NUM_EP-1:0]             in_en_i,
    input  logic [NUM_EP-1:0]             stall_i,
    input  logic [NUM_EP-1:0]             iso_i,
    input  logic [NUM_EP-1:0]             setup_en_i,
    input  logic [NUM_EP-1:0]             rdy_i,
    input  logic [NUM_EP-1:0][BUF_W-1:0]  bufs_i,
    input  logic [NUM_EP-1:0][SIZE_W-1:0] sizes_i,
    input  logic [NUM_EP-1:0]             tgl_i,
    input  logic                          tx_done_i,
    input  logic                          ack_i,
    input  logic                          bad_pkt_i,
    input  logic                          other_tok_i,
    input  logic                          link_rst_i,
    output logic                          tx_start_o,
    output logic [1:0]                    tx_kind_o,
    output logic [BUF_W-1:0]              tx_buf_o,
    output logic [SIZE_W-1:0]             tx_len_o,
    output logic                          tx_data1_o,
    output logic                          in_err_o,
    output logic                          done_o,
    output logic [EP_W-1:0]               done_ep_o,
    output logic                          done_flip_o
);
    localparam int TMO_W = $clog2(ACK_TIMEOUT + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(ACK_TIMEOUT - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [EP_W-1:0]   ep;
        logic              iso;
        logic [TMO_W-1:0]  tmo;
        logic              start;
        rsp_kind_e         kind;
        logic [BUF_W-1:0]  bufid;
        logic [SIZE_W-1:0] len;
        logic              data1;
        logic              err;
    } seq_t;

    seq_t s_d, s_q;

    logic              hit;
    logic [EP_W-1:0]   sel;
    logic [SIZE_W-1:0] sel_len;
    logic              iso_eff;

    assign hit     = (int'(tok_ep_i) < NUM_EP);
    assign sel     = hit ? tok_ep_i : '0;
    assign iso_eff = iso_i[sel] & ~setup_en_i[sel];

    usb_in_len_clamp #(
        .SIZE_W  (SIZE_W),
        .MAX_PKT (MAX_PKT)
    ) u_clamp (
        .size_i (sizes_i[sel]),
        .len_o  (sel_len)
    );

    always_comb begin
        s_d         = s_q;
        s_d.start   = 1'b0;
        s_d.err     = 1'b0;
        done_o      = 1'b0;
        done_flip_o = 1'b0;
        unique case (s_q.state)
            SQ_IDLE: begin
                if (tok_in_i && hit && in_en_i[sel]) begin
                    s_d.start = 1'b1;
                    s_d.ep    = sel;
                    s_d.iso   = iso_eff;
                    if (stall_i[sel] && !iso_eff) begin
                        s_d.kind = RSP_STALL;
                    end else if (rdy_i[sel]) begin
                        s_d.kind  = RSP_DATA;
                        s_d.bufid = bufs_i[sel];
                        s_d.len   = sel_len;
                        s_d.data1 = tgl_i[sel];
                        s_d.state = SQ_SEND;
                    end else begin
                        s_d.kind = RSP_NAK;
                    end
                end
            end
            SQ_SEND: begin
                if (tx_done_i) begin
                    if (s_q.iso) begin
                        done_o    = 1'b1;
                        s_d.state = SQ_IDLE;
                    end else begin
                        s_d.tmo   = '0;
                        s_d.state = SQ_WACK;
                    end
                end
            end
            SQ_WACK: begin
                if (ack_i) begin
                    done_o      = 1'b1;
                    done_flip_o = 1'b1;
                    s_d.state   = SQ_IDLE;
                end else if (bad_pkt_i || other_tok_i) begin
                    s_d.err   = 1'b1;
                    s_d.state = SQ_IDLE;
                end else if (s_q.tmo == TMO_LAST) begin
                    s_d.state = SQ_IDLE;
                end else begin
                    s_d.tmo = s_q.tmo + 1'b1;
                end
            end
            default: s_d.state = SQ_IDLE;
        endcase
        if (link_rst_i) begin
            s_d.state = SQ_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_start_o = s_q.start;
    assign tx_kind_o  = s_q.kind;
    assign tx_buf_o   = s_q.bufid;
    assign tx_len_o   = s_q.len;
    assign tx_data1_o = s_q.data1;
    assign in_err_o   = s_q.err;
    assign done_ep_o  = s_q.ep;
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl #(
    parameter int NUM_EP      = 12,
    parameter int EP_W        = $clog2(NUM_EP),
    parameter int BUF_W       = 5,
    parameter int SIZE_W      = 7,
    parameter int MAX_PKT     = 64,
    parameter int ACK_TIMEOUT = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sw_wr_i,
    input  logic [EP_W-1:0]   sw_ep_i,
    input  logic [BUF_W-1:0]  sw_buf_i,
    input  logic [SIZE_W-1:0] sw_size_i,
    input  logic              sw_rdy_i,
    input  logic [NUM_EP-1:0] pend_clr_i,
    input  logic [NUM_EP-1:0] sent_clr_i,
    input  logic [NUM_EP-1:0] tgl_clr_i,
    input  logic [NUM_EP-1:0] in_en_i,
    input  logic [NUM_EP-1:0] stall_i,
    input  logic [NUM_EP-1:0] iso_i,
    input  logic [NUM_EP-1:0] setup_en_i,
    input  logic              tok_in_i,
    input  logic [EP_W-1:0]   tok_ep_i,
    input  logic              tx_done_i,
    input  logic              ack_i,
    input  logic              bad_pkt_i,
    input  logic              other_tok_i,
    input  logic              setup_rx_i,
    input  logic [EP_W-1:0]   setup_ep_i,
    input  logic              link_rst_i,
    output logic              tx_start_o,
    output logic [1:0]        tx_kind_o,
    output logic [BUF_W-1:0]  tx_buf_o,
    output logic [SIZE_W-1:0] tx_len_o,
    output logic              tx_data1_o,
    output logic              in_err_o,
    output logic [NUM_EP-1:0] rdy_o,
    output logic [NUM_EP-1:0] pend_o,
    output logic [NUM_EP-1:0] sent_o,
    output logic              pkt_sent_irq_o
);
    logic [NUM_EP-1:0][BUF_W-1:0]  bufs;
    logic [NUM_EP-1:0][SIZE_W-1:0] sizes;
    logic [NUM_EP-1:0]             tgl;
    logic                          done;
    logic [EP_W-1:0]               done_ep;
    logic                          done_flip;

    usb_in_ep_regs #(
        .NUM_EP (NUM_EP),
        .EP_W   (EP_W),
        .BUF_W  (BUF_W),
        .SIZE_W (SIZE_W)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sw_wr_i     (sw_wr_i),
        .sw_ep_i     (sw_ep_i),
        .sw_buf_i    (sw_buf_i),
        .sw_size_i   (sw_size_i),
        .sw_rdy_i    (sw_rdy_i),
        .pend_clr_i  (pend_clr_i),
        .sent_clr_i  (sent_clr_i),
        .tgl_clr_i   (tgl_clr_i),
        .done_i      (done),
        .done_ep_i   (done_ep),
        .done_flip_i (done_flip),
        .setup_v_i   (setup_rx_i),
        .setup_ep_i  (setup_ep_i),
        .setup_en_i  (setup_en_i),
        .link_rst_i  (link_rst_i),
        .bufs_o      (bufs),
        .sizes_o     (sizes),
        .rdy_o       (rdy_o),
        .pend_o      (pend_o),
        .sent_o      (sent_o),
        .tgl_o       (tgl)
    );

    usb_in_seq #(
        .NUM_EP      (NUM_EP),
        .EP_W        (EP_W),
        .BUF_W       (BUF_W),
        .SIZE_W      (SIZE_W),
        .MAX_PKT     (MAX_PKT),
        .ACK_TIMEOUT (ACK_TIMEOUT)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tok_in_i    (tok_in_i),
        .tok_ep_i    (tok_ep_i),
        .in_en_i     (in_en_i),
        .stall_i     (stall_i),
        .iso_i       (iso_i),
        .setup_en_i  (setup_en_i),
        .rdy_i       (rdy_o),
        .bufs_i      (bufs),
        .sizes_i     (sizes),
        .tgl_i       (tgl),
        .tx_done_i   (tx_done_i),
        .ack_i       (ack_i),
        .bad_pkt_i   (bad_pkt_i),
        .other_tok_i (other_tok_i),
        .link_rst_i  (link_rst_i),
        .tx_start_o  (tx_start_o),
        .tx_kind_o   (tx_kind_o),
        .tx_buf_o    (tx_buf_o),
        .tx_len_o    (tx_len_o),
        .tx_data1_o  (tx_data1_o),
        .in_err_o    (in_err_o),
        .done_o      (done),
        .done_ep_o   (done_ep),
        .done_flip_o (done_flip)
    );

    assign pkt_sent_irq_o = |sent_o;
endmodule

// File: rtl/usb_in_ep_ctrl_chk.sv
module usb_in_ep_ctrl_chk #(
    parameter int NUM_EP  = 12,
    parameter int EP_W    = 4,
    parameter int SIZE_W  = 7,
    parameter int MAX_PKT = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tx_start_o,
    input logic [1:0]        tx_kind_o,
    input logic [SIZE_W-1:0] tx_len_o,
    input logic              link_rst_i,
    input logic [NUM_EP-1:0] rdy_o,
    input logic [NUM_EP-1:0] pend_o,
    input logic [NUM_EP-1:0] pend_clr_i,
    input logic [NUM_EP-1:0] sent_o,
    input logic [NUM_EP-1:0] sent_clr_i,
    input logic              pkt_sent_irq_o,
    input logic              ack_i,
    input logic              tx_done_i,
    input logic              in_err_o,
    input logic              setup_rx_i,
    input logic [EP_W-1:0]   setup_ep_i,
    input logic [NUM_EP-1:0] setup_en_i
);
    AST_LEN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_start_o && tx_kind_o == 2'd0) |-> (int'(tx_len_o) <= MAX_PKT)); // R5

    AST_LINK_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_rst_i |=> (rdy_o == '0)); // R10

    AST_LINK_RECORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_rst_i |=> ((pend_o & $past(rdy_o)) == $past(rdy_o))); // R10

    AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(pend_o) & ~$past(pend_clr_i) & ~pend_o) == '0)); // R11

    AST_SENT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(sent_o) & ~$past(sent_clr_i) & ~sent_o) == '0)); // R11

    AST_SETUP_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (setup_rx_i && (int'(setup_ep_i) < NUM_EP) && setup_en_i[setup_ep_i])
        |=> !rdy_o[$past(setup_ep_i)]); // R9

    AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_err_o |=> !in_err_o); // R8

    AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pkt_sent_irq_o) |-> ($past(ack_i) || $past(tx_done_i))); // R12
endmodule

bind usb_in_ep_ctrl usb_in_ep_ctrl_chk #(
    .NUM_EP  (NUM_EP),
    .EP_W    (EP_W),
    .SIZE_W  (SIZE_W),
    .MAX_PKT (MAX_PKT)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tx_start_o     (tx_start_o),
    .tx_kind_o      (tx_kind_o),
    .tx_len_o       (tx_len_o),
    .link_rst_i     (link_rst_i),
    .rdy_o          (rdy_o),
    .pend_o         (pend_o),
    .pend_clr_i     (pend_clr_i),
    .sent_o         (sent_o),
    .sent_clr_i     (sent_clr_i),
    .pkt_sent_irq_o (pkt_sent_irq_o),
    .ack_i          (ack_i),
    .tx_done_i      (tx_done_i),
    .in_err_o       (in_err_o),
    .setup_rx_i     (setup_rx_i),
    .setup_ep_i     (setup_ep_i),
    .setup_en_i     (setup_en_i)
);

// File: tb/sim_usb_in_ep_ctrl.sv
module sim_usb_in_ep_ctrl;
    localparam int N    = 3;
    localparam int EW   = 2;
    localparam int BW   = 5;
    localparam int SW   = 7;
    localparam int MAXP = 64;
    localparam int TMO  = 8;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          sw_wr_i = 1'b0;
    logic [EW-1:0] sw_ep_i = '0;
    logic [BW-1:0] sw_buf_i = '0;
    logic [SW-1:0] sw_size_i = '0;
    logic          sw_rdy_i = 1'b0;
    logic [N-1:0]  pend_clr_i = '0, sent_clr_i = '0, tgl_clr_i = '0;
    logic [N-1:0]  in_en_i = '0, stall_i = '0, iso_i = '0, setup_en_i = '0;
    logic          tok_in_i = 1'b0;
    logic [EW-1:0] tok_ep_i = '0;
    logic          tx_done_i = 1'b0, ack_i = 1'b0, bad_pkt_i = 1'b0, other_tok_i = 1'b0;
    logic          setup_rx_i = 1'b0;
    logic [EW-1:0] setup_ep_i = '0;
    logic          link_rst_i = 1'b0;
    logic          tx_start_o, tx_data1_o, in_err_o, pkt_sent_irq_o;
    logic [1:0]    tx_kind_o;
    logic [BW-1:0] tx_buf_o;
    logic [SW-1:0] tx_len_o;
    logic [N-1:0]  rdy_o, pend_o, sent_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit m_tgl [N];

    always #5 clk_i = ~clk_i;

    usb_in_ep_ctrl #(
        .NUM_EP (N), .EP_W (EW), .BUF_W (BW), .SIZE_W (SW),
        .MAX_PKT (MAXP), .ACK_TIMEOUT (TMO)
    ) u0 (.*);

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk_i);
    endtask

    task automatic sw_write(input int ep, input int b, input int sz, input bit r);
        sw_wr_i = 1'b1; sw_ep_i = EW'(ep); sw_buf_i = BW'(b);
        sw_size_i = SW'(sz); sw_rdy_i = r;
        tick;
        sw_wr_i = 1'b0;
    endtask

    task automatic tok(input int ep);
        tok_in_i = 1'b1; tok_ep_i = EW'(ep);
        tick;
        tok_in_i = 1'b0;
    endtask

    task automatic done_pulse;
        tx_done_i = 1'b1; tick; tx_done_i = 1'b0;
    endtask

    task automatic ack_pulse;
        ack_i = 1'b1; tick; ack_i = 1'b0;
    endtask

    task automatic clr_sent(input int mask);
        sent_clr_i = N'(mask); tick; sent_clr_i = '0;
    endtask

    function automatic int clamp(input int sz);
        return (sz > MAXP) ? MAXP : sz;
    endfunction

    // full data exchange with ACK on a non-isochronous endpoint
    task automatic send_acked(input int ep, input int b, input int sz, input string tag);
        sw_write(ep, b, sz, 1'b1);
        tok(ep);
        check({tag, " start"}, int'(tx_start_o), 1);
        check({tag, " kind"}, int'(tx_kind_o), 0);
        check({tag, " len"}, int'(tx_len_o), clamp(sz));
        check({tag, " data1"}, int'(tx_data1_o), int'(m_tgl[ep]));
        done_pulse;
        ack_pulse;
        m_tgl[ep] = ~m_tgl[ep];
        clr_sent(1 << ep);
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_tgl[i] = 1'b0;
        repeat (3) tick;
        // R1 reset state
        check("R1 rdy", int'(rdy_o), 0);
        check("R1 pend", int'(pend_o), 0);
        check("R1 sent", int'(sent_o), 0);
        check("R1 irq", int'(pkt_sent_irq_o), 0);
        check("R1 start", int'(tx_start_o), 0);
        rst_ni = 1'b1;
        tick;
        check("R1 idle after release", int'(tx_start_o), 0);

        // sweep: endpoint x {in_en, stall, iso, setup_en, ready}
        for (int ep = 0; ep <= N; ep++) begin
            for (int cfg = 0; cfg < 32; cfg++) begin
                bit en, st, io, se, r, isoe;
                int sz, b, exp_kind;
                en = cfg[0]; st = cfg[1]; io = cfg[2]; se = cfg[3]; r = cfg[4];
                sz = (cfg * 9 + ep * 23) % 128;
                b  = (cfg + ep * 11) % 32;
                isoe = io & ~se;
                if (ep < N) begin
                    in_en_i = '0; stall_i = '0; iso_i = '0; setup_en_i = '0;
                    in_en_i[ep] = en; stall_i[ep] = st; iso_i[ep] = io; setup_en_i[ep] = se;
                    sw_write(ep, b, sz, r);
                end else begin
                    in_en_i = {N{en}}; stall_i = {N{st}};
                    iso_i = {N{io}}; setup_en_i = {N{se}};
                end
                tok(ep);
                if (ep >= N || !en) begin
                    check("R2 ignored token", int'(tx_start_o), 0);
                end else begin
                    check("R3/R4/R5 start", int'(tx_start_o), 1);
                    exp_kind = (st && !isoe) ? 2 : (r ? 0 : 1);
                    if (exp_kind == 2) check("R3 stall", int'(tx_kind_o), 2);
                    else if (exp_kind == 1) check("R4 nak", int'(tx_kind_o), 1);
                    else begin
                        check("R5 data kind", int'(tx_kind_o), 0);
                        check("R5 buffer", int'(tx_buf_o), b);
                        check("R5 length", int'(tx_len_o), clamp(sz));
                        check("R6 toggle", int'(tx_data1_o), int'(m_tgl[ep]));
                        done_pulse;
                        if (isoe) begin
                            check("R7 iso rdy", int'(rdy_o[ep]), 0);
                            check("R7 iso sent", int'(sent_o[ep]), 1);
                        end else begin
                            check("R6 waits for ack", int'(rdy_o[ep]), 1);
                            ack_pulse;
                            check("R6 rdy cleared", int'(rdy_o[ep]), 0);
                            check("R6 sent set", int'(sent_o[ep]), 1);
                            m_tgl[ep] = ~m_tgl[ep];
                        end
                        check("R12 irq high", int'(pkt_sent_irq_o), 1);
                        clr_sent(1 << ep);
                        check("R12 irq low", int'(pkt_sent_irq_o), 0);
                    end
                end
                tick;
            end
        end
        in_en_i = '1; stall_i = '0; iso_i = '0; setup_en_i = '0;

        // R5 clamp boundaries on endpoint 0
        send_acked(0, 3, 0, "R5 size0");
        send_acked(0, 4, 63, "R5 size63");
        send_acked(0, 5, 64, "R5 size64");
        send_acked(0, 6, 65, "R5 size65");
        send_acked(0, 7, 127, "R5 size127");

        // R8 bad packet, other token, timeout
        sw_write(1, 9, 10, 1'b1);
        tok(1); done_pulse;
        bad_pkt_i = 1'b1; tick; bad_pkt_i = 1'b0;
        check("R8 err on bad packet", int'(in_err_o), 1);
        check("R8 rdy kept", int'(rdy_o[1]), 1);
        check("R8 sent untouched", int'(sent_o[1]), 0);
        tick;
        check("R8 err one cycle", int'(in_err_o), 0);
        tok(1);
        check("R8 retry same toggle", int'(tx_data1_o), int'(m_tgl[1]));
        done_pulse;
        other_tok_i = 1'b1; tick; other_tok_i = 1'b0;
        check("R8 err on other token", int'(in_err_o), 1);
        tok(1); done_pulse;
        for (int k = 0; k < TMO + 4; k++) begin
            tick;
            check("R8 no err on timeout", int'(in_err_o), 0);
        end
        tok(1);
        check("R8 idle after timeout", int'(tx_start_o), 1);
        done_pulse; ack_pulse; m_tgl[1] = ~m_tgl[1]; clr_sent(2);

        // R9 setup cancellation
        setup_en_i = 3'b100;
        sw_write(2, 1, 8, 1'b1);
        sw_write(1, 2, 8, 1'b1);
        setup_rx_i = 1'b1; setup_ep_i = 2'd2; tick; setup_rx_i = 1'b0;
        check("R9 rdy cleared", int'(rdy_o[2]), 0);
        check("R9 pend set", int'(pend_o[2]), 1);
        setup_rx_i = 1'b1; setup_ep_i = 2'd1; tick; setup_rx_i = 1'b0;
        check("R9 setup ignored rdy", int'(rdy_o[1]), 1);
        check("R9 setup ignored pend", int'(pend_o[1]), 0);
        pend_clr_i = 3'b100; tick; pend_clr_i = '0;
        check("R11 pend w1c", int'(pend_o[2]), 0);
        sw_write(2, 1, 8, 1'b1);
        setup_rx_i = 1'b1; setup_ep_i = 2'd2; pend_clr_i = 3'b100; tick;
        setup_rx_i = 1'b0; pend_clr_i = '0;
        check("R11 set wins over clear", int'(pend_o[2]), 1);
        pend_clr_i = 3'b100; tick; pend_clr_i = '0;
        setup_en_i = '0;

        // R10 link reset: ep0 and ep1 ready (ep1 from R9), ep2 not
        sw_write(0, 1, 4, 1'b1);
        check("R10 toggle nonzero before", int'(m_tgl[0]) | int'(m_tgl[1]) | int'(m_tgl[2]), 1);
        link_rst_i = 1'b1; tick; link_rst_i = 1'b0;
        check("R10 rdy cleared", int'(rdy_o), 0);
        check("R10 pend for armed", int'(pend_o), 3);
        for (int i = 0; i < N; i++) m_tgl[i] = 1'b0;
        pend_clr_i = '1; tick; pend_clr_i = '0;
        send_acked(0, 2, 5, "R10 toggle reset");
        send_acked(2, 2, 5, "R10 toggle reset ep2");

        // R13 toggle clear: ep1 toggle now DATA0 -> ack once -> DATA1
        send_acked(1, 3, 3, "R13 prep");
        check("R13 model", int'(m_tgl[1]), 1);
        tgl_clr_i = 3'b010; tick; tgl_clr_i = '0;
        m_tgl[1] = 1'b0;
        send_acked(1, 3, 3, "R13 after clear");

        // R12 with two sent flags, R11 sent sticky
        sw_write(0, 1, 1, 1'b1); tok(0); done_pulse; ack_pulse;
        sw_write(2, 1, 1, 1'b1); tok(2); done_pulse; ack_pulse;
        repeat (3) tick;
        check("R11 sent sticky", int'(sent_o), 5);
        clr_sent(1);
        check("R12 irq one left", int'(pkt_sent_irq_o), 1);
        clr_sent(4);
        check("R12 irq none left", int'(pkt_sent_irq_o), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule